// File: doc/BRIEF.md
# Distributed Flush-Recovery Controller for a Five-Stage Pipeline

This block handles recovery from timing errors in a pipeline without a pipeline-wide stall. A stage that holds a valid instruction and flags an error has its result replaced by a bubble on the next transfer. At the same time a recovery token is created. The token holds the failing stage's index and the program counter of the instruction that failed. Each cycle the token moves one slot toward the end of the pipe, riding alongside the bubble. When it reaches the last slot, the controller squashes every stage, which by then holds only younger work. It also steers fetch back to the failed instruction.

Stages are numbered 0 (fetch) to NS-1 (the write-back register). The last register is a stabilizer and cannot report errors, so only stages 0 to NS-2 have error inputs. Instructions that are older than the failing one drain normally and commit. The penalty of an error at stage k is NS-1-k cycles until the redirect, plus the refill of the pipe. Every signal the controller uses travels between neighbouring slots, so none is broadcast.

Top module: `pipe_flush_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no error input, `redirect_o`, `flush_o` and `bubble_o` are all zero.
- R2: If stage k (0..NS-2) is valid and its error input is high, `bubble_o[k]` is high in the same cycle. The environment then passes an invalid slot to stage k+1.
- R3: An error input on a stage whose valid bit is low is ignored. It raises no bubble and never leads to a redirect.
- R4: A recovery token moves one stage per cycle. An error taken at stage k in cycle t raises `redirect_o` in cycle t+(NS-1-k), for a single cycle. For the stage just before write-back, this is the next cycle.
- R5: During a redirect, `redirect_pc_o` is the program counter that the failing stage presented in the error cycle, and `redirect_stage_o` is that stage's index (0..NS-2).
- R6: `flush_o` is all ones in a redirect cycle and zero otherwise. In the cycle after a redirect, fetch restarts at `redirect_pc_o`.
- R7: If several valid stages report errors in the same cycle, only the highest-numbered (oldest) stage creates a token, so its index and program counter are the ones redirected.
- R8: A redirect discards every token still in flight and every error taken in the same cycle, so `redirect_o` is never high in two consecutive cycles.
- R9: Under random error injection, instructions reach write-back exactly once each and in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_valid_i | input | NS | Valid bit of each stage register, bit k = stage k |
| stage_err_i | input | NS-1 | Timing-error flag of stages 0..NS-2 |
| stage_pc_i | input | NS*PCW | Program counter tag of each stage, stage k at bits k*PCW +: PCW |
| bubble_o | output | NS-1 | Replace stage k's result with a bubble on the next transfer |
| flush_o | output | NS-1 | Squash the contents of stages 0..NS-2 |
| redirect_o | output | 1 | Restart fetch this cycle |
| redirect_stage_o | output | $clog2(NS) | Index of the stage that failed |
| redirect_pc_o | output | PCW | Program counter to fetch from next |

## Verification
The bench goes after these cases:
- An error on an empty slot. A design that does not gate errors with valid would bubble it and later redirect to a stale program counter.
- Errors at the first and last error-capable stages, which give the longest and shortest token trips. A design with wrong token timing would redirect early or late, and an instruction would then commit twice or be lost.
- Errors on several stages in one cycle. Picking a younger stage would re-execute from the wrong point.
- Errors arriving in the very cycle of a redirect. A controller that kept them would issue a second, spurious redirect.
- A long random run that checks every commit against a strictly increasing program counter. Any of the faults above would show up there as a duplicate or a gap.

// File: rtl/pipe_flush_ctrl.sv
`timescale 1ns/1ps
module pipe_flush_ctrl #(
  parameter int NS  = 5,
  parameter int PCW = 32
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NS-1:0]         stage_valid_i,
  input  logic [NS-2:0]         stage_err_i,
  input  logic [NS*PCW-1:0]     stage_pc_i,
  output logic [NS-2:0]         bubble_o,
  output logic [NS-2:0]         flush_o,
  output logic                  redirect_o,
  output logic [$clog2(NS)-1:0] redirect_stage_o,
  output logic [PCW-1:0]        redirect_pc_o
);
  localparam int IDW = $clog2(NS);

  logic [NS-1:1]  tok_v;
  logic [PCW-1:0] tok_pc [NS-1:1];
  logic [IDW-1:0] tok_id [NS-1:1];

  logic [NS-1:1]  sh_v;
  logic [PCW-1:0] sh_pc [NS-1:1];
  logic [IDW-1:0] sh_id [NS-1:1];

  logic           pick_v;
  logic [IDW-1:0] pick;

  assign bubble_o = stage_err_i & stage_valid_i[NS-2:0];

  always_comb begin
    pick_v = 1'b0;
    pick   = '0;
    for (int k = 0; k < NS-1; k++) begin
      if (bubble_o[k]) begin
        pick_v = 1'b1;
        pick   = IDW'(k);
      end
    end
  end

  for (genvar k = 1; k < NS; k++) begin : g_link
    if (k == 1) begin : g_head
      assign sh_v[k]  = 1'b0;
      assign sh_pc[k] = '0;
      assign sh_id[k] = '0;
    end else begin : g_body
      assign sh_v[k]  = tok_v[k-1];
      assign sh_pc[k] = tok_pc[k-1];
      assign sh_id[k] = tok_id[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_v <= '0;
    end else begin
      for (int k = 1; k < NS; k++) begin
        if (redirect_o) begin
          tok_v[k] <= 1'b0;
        end else if (pick_v && pick == IDW'(k-1)) begin
          tok_v[k]  <= 1'b1;
          tok_pc[k] <= stage_pc_i[(k-1)*PCW +: PCW];
          tok_id[k] <= pick;
        end else begin
          tok_v[k]  <= sh_v[k];
          tok_pc[k] <= sh_pc[k];
          tok_id[k] <= sh_id[k];
        end
      end
    end
  end

  assign redirect_o       = tok_v[NS-1];
  assign redirect_pc_o    = tok_pc[NS-1];
  assign redirect_stage_o = tok_id[NS-1];
  assign flush_o          = {(NS-1){redirect_o}};
endmodule

module pipe_flush_ctrl_chk #(
  parameter int NS  = 5,
  parameter int PCW = 32
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NS-1:0]         stage_valid_i,
  input logic [NS-2:0]         stage_err_i,
  input logic [NS*PCW-1:0]     stage_pc_i,
  input logic [NS-2:0]         bubble_o,
  input logic                  redirect_o,
  input logic [$clog2(NS)-1:0] redirect_stage_o,
  input logic [PCW-1:0]        redirect_pc_o
);
  localparam int IDW = $clog2(NS);

  p_redirect_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o)
    else $error("redirect held two cycles");

  p_last_stage_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_o && stage_err_i[NS-2] && stage_valid_i[NS-2]) |=>
      (redirect_o && redirect_pc_o == $past(stage_pc_i[(NS-2)*PCW +: PCW])
                  && redirect_stage_o == IDW'(NS-2)))
    else $error("late-stage error not redirected next cycle");

  p_stage_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (redirect_stage_o <= IDW'(NS-2)))
    else $error("redirect stage out of range");

  p_invalid_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bubble_o & ~stage_valid_i[NS-2:0]) == '0)
    else $error("bubble on an empty slot");
endmodule

bind pipe_flush_ctrl pipe_flush_ctrl_chk #(.NS(NS), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stage_valid_i(stage_valid_i), .stage_err_i(stage_err_i),
  .stage_pc_i(stage_pc_i), .bubble_o(bubble_o), .redirect_o(redirect_o),
  .redirect_stage_o(redirect_stage_o), .redirect_pc_o(redirect_pc_o)
);

// File: tb/tb_pipe_flush_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_flush_ctrl;
  localparam int NS  = 5;
  localparam int PCW = 32;
  localparam int IDW = $clog2(NS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NS-1:0]     sv = '0;
  logic [NS-2:0]     se = '0;
  logic [NS*PCW-1:0] spc = '0;
  logic [NS-2:0]     bubble_o, flush_o;
  logic              redirect_o;
  logic [IDW-1:0]    redirect_stage_o;
  logic [PCW-1:0]    redirect_pc_o;

  pipe_flush_ctrl #(.NS(NS), .PCW(PCW)) dut (
    .clk(clk), .rst_n(rst_n), .stage_valid_i(sv), .stage_err_i(se), .stage_pc_i(spc),
    .bubble_o(bubble_o), .flush_o(flush_o), .redirect_o(redirect_o),
    .redirect_stage_o(redirect_stage_o), .redirect_pc_o(redirect_pc_o));

  typedef struct { int due; int pc; int stg; bit multi; } tok_t;
  tok_t pend[$];
  bit   pv  [NS];
  int   ppc [NS];
  int   fetch_pc = 0, next_commit = 0, cyc = 0, commits = 0;
  int   checks = 0, fails = 0;
  bit   prev_redir = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic [NS-2:0] e);
    logic [NS-2:0] eff, pvm;
    bit   hit;
    tok_t h;
    int   k_old, nerr;
    @(negedge clk);
    for (int k = 0; k < NS; k++) begin
      sv[k] = pv[k];
      spc[k*PCW +: PCW] = ppc[k];
    end
    se = e;
    #1;
    for (int k = 0; k < NS-1; k++) pvm[k] = pv[k];
    eff = e & pvm;
    chk(bubble_o == eff, ((e & ~pvm) != '0) ? "R3" : "R2", "bubble", bubble_o, eff);
    hit = 0;
    foreach (pend[i]) if (pend[i].due == cyc) begin hit = 1; h = pend[i]; end
    chk(redirect_o == hit, prev_redir ? "R8" : "R4", "redirect", redirect_o, hit);
    if (hit) begin
      chk(redirect_pc_o == PCW'(h.pc), "R5", "redirect pc", redirect_pc_o, h.pc);
      chk(redirect_stage_o == IDW'(h.stg), h.multi ? "R7" : "R5", "redirect stage",
          redirect_stage_o, h.stg);
      chk(flush_o == '1, "R6", "flush on redirect", flush_o, (1 << (NS-1)) - 1);
    end else begin
      chk(flush_o == '0, "R6", "flush idle", flush_o, 0);
    end
    if (pv[NS-1]) begin
      chk(ppc[NS-1] == next_commit, "R9", "commit pc", ppc[NS-1], next_commit);
      next_commit = ppc[NS-1] + 1;
      commits++;
    end
    if (hit) pend.delete();
    else if (eff != '0) begin
      k_old = 0; nerr = 0;
      for (int k = 0; k < NS-1; k++) if (eff[k]) begin k_old = k; nerr++; end
      h.due = cyc + NS-1-k_old; h.pc = ppc[k_old]; h.stg = k_old; h.multi = (nerr > 1);
      pend.push_back(h);
    end
    for (int k = NS-1; k >= 1; k--) begin
      pv[k]  = pv[k-1] && !eff[k-1] && !hit;
      ppc[k] = ppc[k-1];
    end
    pv[0]  = 1'b1;
    ppc[0] = hit ? h.pc : fetch_pc;
    fetch_pc = ppc[0] + 1;
    prev_redir = hit;
    cyc++;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NS; k++) begin pv[k] = 0; ppc[k] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(redirect_o == 0, "R1", "redirect in reset", redirect_o, 0);
    chk(flush_o == '0, "R1", "flush in reset", flush_o, 0);
    chk(bubble_o == '0, "R1", "bubble in reset", bubble_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step('0);
    step(4'b1000);                     // R3: late stage empty
    repeat (6) step('0);
    step(4'b1000);                     // R4: one-cycle trip
    repeat (6) step('0);
    step(4'b0001);                     // R4: longest trip
    repeat (8) step('0);
    step(4'b0110);                     // R7: oldest of two wins
    repeat (8) step('0);
    step(4'b1000);
    step(4'b1111);                     // R8: errors in redirect cycle dropped
    repeat (8) step('0);
    for (int n = 0; n < 2000; n++) begin
      logic [NS-2:0] e;
      for (int k = 0; k < NS-1; k++) e[k] = ($urandom_range(99) < 8);
      step(e);
    end
    repeat (8) step('0);
    chk(commits > 500, "R9", "forward progress", commits, 500);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule